// File: doc/BRIEF.md
# Z80 memory region mapper

This block sits between a Z80 bus front end and the storage behind it. Each memory access is classified through a table of 128 entries, one for every 512-byte block of the 64KB space. An entry gives the kind of storage that backs the block, a bank, a block-sized offset into that bank, a count of extra T-states, and a flag. When the flag is set, a host-bus access waits for the host clock's T1 state before it starts. The block returns a route, a translated backing address, a write strobe for internal RAM, a start pulse for pass-through cycles and a WAIT request.

One clock period of the block is one T-state. A request is sampled in T1. The decoded result appears in T2, and WAIT is raised from T2. Two global extra-wait settings can stretch cycles further: one for M1 opcode fetches and one for I/O cycles. A single configuration port writes table entries and the two global settings. After reset the map is ready for use with no configuration. The backing memories, the host bus drivers and image loading sit outside this block.

Top module: `z80_region_mapper`

## Requirements
- R1: After reset the map reads blocks 0x0000–0x0FFF as ROM, 0x1000–0xCFFF as RAM and 0xD000–0xFFFF as pass-through with 2 wait T-states and T1 sync set. All reset entries have bank 0 and offset equal to their own block index.
- R2: For a memory access, xaddr_o = bank × 65536 + offset × 512 + (address mod 512). The result is valid in the cycle after the request, together with valid_o.
- R3: route_o encodes the entry type as 0 = RAM, 1 = ROM, 2 = pass-through, 3 = function handler. phys_go_o only pulses for route 2.
- R4: wr_stb_o pulses for one cycle, together with valid_o, only for a memory write (kind 2) to a RAM block. Writes to ROM, pass-through and function blocks raise no strobe.
- R5: wait_o is high for exactly N consecutive cycles starting with the valid_o cycle, where N is the total wait for the access. Memory reads and writes use the region count.
- R6: An opcode fetch (kind 0) adds the global fetch extra wait to the region count. Other memory kinds do not add it.
- R7: I/O reads and writes (kinds 3, 4) bypass the table. They route as pass-through with xaddr_o equal to the address, pulse phys_go_o in the valid cycle, and wait exactly the global I/O extra.
- R8: The global fetch extra saturates at 4 and the I/O extra saturates at 8. Both are 0 after reset.
- R9: For a pass-through block with the sync flag set, wait_o stays high until host_t1_i is sampled high at or after the valid cycle. phys_go_o then pulses in the next cycle, and the region wait follows. With host_t1_i first high in cycle s after the request, the total wait is s + N and phys_go_o falls in cycle s + 1. Without the flag, phys_go_o pulses in the valid cycle.
- R10: The configuration port writes an entry when cfg_sel_i[7] = 0, at index cfg_sel_i[6:0]. The data fields are [18:17] type, [16:11] bank, [10:4] offset, [3:1] wait, [0] sync. When cfg_sel_i[7] = 1 it writes the globals: fetch extra from [2:0] and I/O extra from [6:3].
- R11: A request presented while wait_o is high is ignored. It produces no valid_o and no wr_stb_o.
- R12: After reset valid_o, wr_stb_o, phys_go_o and wait_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | T-state clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled in T1 |
| kind_i | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| addr_i | input | 16 | Z80 address |
| host_t1_i | input | 1 | Host clock is in T1 |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 8 | Entry index, or globals when bit 7 is set |
| cfg_data_i | input | 19 | Entry fields or global settings |
| valid_o | output | 1 | Decoded result valid, one cycle |
| route_o | output | 2 | Route of the last accepted access |
| xaddr_o | output | 22 | Translated backing address |
| wr_stb_o | output | 1 | Internal RAM write strobe |
| phys_go_o | output | 1 | Start of a host-bus cycle |
| wait_o | output | 1 | WAIT request to the CPU |

## Verification
The main function is tried with fetches, reads and writes that land on each of the three reset regions and on their boundary blocks. These accesses show whether the reset map and the route encoding agree. Reprogrammed entries with nonzero bank and offset separate a correct address concatenation from an identity mapping. Sync tests place the host T1 at different distances from the request, and zero and nonzero region waits are mixed in. Together these show whether the sync delay and the region wait add up, and where the start pulse falls. Global settings written beyond their limits, and a second request inside a wait window, test saturation and the refusal of requests while busy.

// File: rtl/zrm_pkg.sv
package zrm_pkg;
  parameter int ADDR_W  = 16;
  parameter int BLK_W   = 9;
  parameter int IDX_W   = ADDR_W - BLK_W;
  parameter int NUM_BLK = 1 << IDX_W;
  parameter int BANK_W  = 6;
  parameter int RWAIT_W = 3;
  parameter int FX_MAX  = 4;
  parameter int IO_MAX  = 8;
  parameter int FX_W    = 3;
  parameter int IO_W    = 4;
  parameter int TOT_W   = 4;
  parameter int XADDR_W = BANK_W + ADDR_W;

  typedef enum logic [1:0] {RT_RAM = 2'd0, RT_ROM = 2'd1, RT_PHYS = 2'd2, RT_FUNC = 2'd3} route_e;
  typedef enum logic [2:0] {AK_FETCH = 3'd0, AK_MRD = 3'd1, AK_MWR = 3'd2,
                            AK_IORD = 3'd3, AK_IOWR = 3'd4} kind_e;

  typedef struct packed {
    route_e               rtype;
    logic [BANK_W-1:0]    bank;
    logic [IDX_W-1:0]     boff;
    logic [RWAIT_W-1:0]   rwait;
    logic                 sync;
  } map_ent_t;

  parameter int ENT_W = $bits(map_ent_t);
endpackage

// File: rtl/zrm_table.sv
module zrm_table
  import zrm_pkg::*;
#(
  parameter int ROM_END   = 8,
  parameter int RAM_END   = 104,
  parameter int PHYS_WAIT = 2,
  parameter int PHYS_SYNC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W:0]    sel_i,
  input  logic [ENT_W-1:0]  data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output map_ent_t          ent_o,
  output logic [FX_W-1:0]   fx_o,
  output logic [IO_W-1:0]   iox_o
);
  map_ent_t tbl [NUM_BLK];
  logic ent_we;
  assign ent_we = we_i && !sel_i[IDX_W];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_ent
    map_ent_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q.rtype <= (b < ROM_END) ? RT_ROM : ((b < RAM_END) ? RT_RAM : RT_PHYS);
        ent_q.bank  <= '0;
        ent_q.boff  <= IDX_W'(b);
        ent_q.rwait <= (b >= RAM_END) ? RWAIT_W'(PHYS_WAIT) : '0;
        ent_q.sync  <= (b >= RAM_END) && (PHYS_SYNC != 0);
      end else if (ent_we && sel_i[IDX_W-1:0] == IDX_W'(b)) begin
        ent_q <= map_ent_t'(data_i);
      end
    end
    assign tbl[b] = ent_q;
  end

  assign ent_o = tbl[idx_i];

  // globals saturate at their limits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fx_o  <= '0;
      iox_o <= '0;
    end else if (we_i && sel_i[IDX_W]) begin
      fx_o  <= (data_i[FX_W-1:0] > FX_W'(FX_MAX)) ? FX_W'(FX_MAX) : data_i[FX_W-1:0];
      iox_o <= (data_i[FX_W+IO_W-1:FX_W] > IO_W'(IO_MAX)) ? IO_W'(IO_MAX)
                                                         : data_i[FX_W+IO_W-1:FX_W];
    end
  end

  p_fx_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_o <= FX_W'(FX_MAX));
  p_io_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iox_o <= IO_W'(IO_MAX));
endmodule

// File: rtl/zrm_decode.sv
module zrm_decode
  import zrm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2:0]         kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               busy_i,
  input  map_ent_t           ent_i,
  input  logic [FX_W-1:0]    fx_i,
  input  logic [IO_W-1:0]    iox_i,
  output logic               valid_o,
  output route_e             route_o,
  output logic [XADDR_W-1:0] xaddr_o,
  output logic               wr_stb_o,
  output logic               ld_o,
  output logic [TOT_W-1:0]   ld_wait_o,
  output logic               ld_sync_o,
  output logic               ld_go_o
);
  logic is_io, kind_ok, accept, wr_d;
  route_e route_d;
  logic [XADDR_W-1:0] xaddr_d;

  always_comb begin
    is_io   = (kind_i == AK_IORD) || (kind_i == AK_IOWR);
    kind_ok = kind_i <= AK_IOWR;
    accept  = req_i && !busy_i && kind_ok;
    route_d = is_io ? RT_PHYS : ent_i.rtype;
    xaddr_d = is_io ? XADDR_W'(addr_i) : {ent_i.bank, ent_i.boff, addr_i[BLK_W-1:0]};
    wr_d    = (kind_i == AK_MWR) && (ent_i.rtype == RT_RAM);
    if (is_io) ld_wait_o = TOT_W'(iox_i);
    else       ld_wait_o = TOT_W'(ent_i.rwait) + ((kind_i == AK_FETCH) ? TOT_W'(fx_i) : '0);
    ld_sync_o = !is_io && (ent_i.rtype == RT_PHYS) && ent_i.sync;
    ld_go_o   = (route_d == RT_PHYS) && !ld_sync_o;
    ld_o      = accept;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_stb_o <= 1'b0;
      route_o  <= RT_RAM;
      xaddr_o  <= '0;
    end else begin
      valid_o  <= accept;
      wr_stb_o <= accept && wr_d;
      if (accept) begin
        route_o <= route_d;
        xaddr_o <= xaddr_d;
      end
    end
  end

  p_wr_ram_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (valid_o && route_o == RT_RAM));
  p_idle_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$past(busy_i));
endmodule

// File: rtl/zrm_waitgen.sv
module zrm_waitgen
  import zrm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [TOT_W-1:0] wait_i,
  input  logic             sync_i,
  input  logic             go_i,
  input  logic             host_t1_i,
  output logic             wait_o,
  output logic             phys_go_o
);
  logic [TOT_W-1:0] cnt_q;
  logic pend_q;

  // sync hold first, then the stretch count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      phys_go_o <= 1'b0;
    end else if (ld_i) begin
      cnt_q     <= wait_i;
      pend_q    <= sync_i;
      phys_go_o <= go_i;
    end else begin
      phys_go_o <= pend_q && host_t1_i;
      if (pend_q && host_t1_i) pend_q <= 1'b0;
      else if (!pend_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wait_o = pend_q || (cnt_q != '0);

  p_sync_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> phys_go_o);
  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !pend_q && !ld_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_go_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_go_o |=> !phys_go_o);
endmodule

// File: rtl/z80_region_mapper.sv
module z80_region_mapper
  import zrm_pkg::*;
#(
  parameter int ROM_END_BLK = 8,
  parameter int RAM_END_BLK = 104,
  parameter int PHYS_WAIT   = 2,
  parameter int PHYS_SYNC   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2:0]         kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               host_t1_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W:0]     cfg_sel_i,
  input  logic [ENT_W-1:0]   cfg_data_i,
  output logic               valid_o,
  output logic [1:0]         route_o,
  output logic [XADDR_W-1:0] xaddr_o,
  output logic               wr_stb_o,
  output logic               phys_go_o,
  output logic               wait_o
);
  map_ent_t ent;
  logic [FX_W-1:0] fx;
  logic [IO_W-1:0] iox;
  logic ld, ld_sync, ld_go;
  logic [TOT_W-1:0] ld_wait;
  route_e route;

  zrm_table #(
    .ROM_END(ROM_END_BLK), .RAM_END(RAM_END_BLK),
    .PHYS_WAIT(PHYS_WAIT), .PHYS_SYNC(PHYS_SYNC)
  ) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .idx_i(addr_i[ADDR_W-1:BLK_W]),
    .ent_o(ent), .fx_o(fx), .iox_o(iox)
  );

  zrm_decode u_decode (
    .clk_i, .rst_ni, .req_i, .kind_i, .addr_i,
    .busy_i(wait_o), .ent_i(ent), .fx_i(fx), .iox_i(iox),
    .valid_o, .route_o(route), .xaddr_o, .wr_stb_o,
    .ld_o(ld), .ld_wait_o(ld_wait), .ld_sync_o(ld_sync), .ld_go_o(ld_go)
  );

  zrm_waitgen u_wait (
    .clk_i, .rst_ni, .ld_i(ld), .wait_i(ld_wait), .sync_i(ld_sync),
    .go_i(ld_go), .host_t1_i, .wait_o, .phys_go_o
  );

  assign route_o = route;

  p_go_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_go_o |-> route == RT_PHYS);
endmodule

// File: tb/z80_region_mapper_tb.sv
module z80_region_mapper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] kind = '0;
  logic [15:0] addr = '0;
  logic host_t1 = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_sel = '0;
  logic [18:0] cfg_data = '0;
  logic valid, wr_stb, phys_go, wait_s;
  logic [1:0] route;
  logic [21:0] xaddr;

  always #2 clk = ~clk;

  z80_region_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .host_t1_i(host_t1), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .valid_o(valid), .route_o(route), .xaddr_o(xaddr), .wr_stb_o(wr_stb),
    .phys_go_o(phys_go), .wait_o(wait_s)
  );

  typedef struct {
    string tag; int route; int xaddr; int wr; int wt; int go;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int mon_done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per valid pulse
  initial begin
    forever begin
      @(negedge clk);
      if (valid) begin
        if (q.size() == 0) begin
          chk("R11", "unexpected valid", 1, 0);
        end else begin
          exp_t it;
          int w, go_at, extra, len;
          it = q.pop_front();
          chk(it.tag, "route", int'(route), it.route);
          chk(it.tag, "xaddr", int'(xaddr), it.xaddr);
          chk(it.tag, "wr_stb", int'(wr_stb), it.wr);
          w = 0; go_at = 0; extra = 0;
          len = it.wt + it.go + 3;
          for (int i = 1; i <= len; i++) begin
            if (i > 1) @(negedge clk);
            if (wait_s) w++;
            if (phys_go && go_at == 0) go_at = i;
            if (i > 1 && (valid || wr_stb)) extra++;
          end
          chk(it.tag, "wait cycles", w, it.wt);
          chk(it.tag, "go cycle", go_at, it.go);
          chk(it.tag, "stray valid/strobe", extra, 0);
          mon_done++;
        end
      end
    end
  end

  task automatic drive(input string tag, input logic [2:0] k, input logic [15:0] a,
                       input int er, input int ex, input int ew, input int ewt,
                       input int ego, input int t1_at, input bit poke);
    exp_t it;
    int tgt;
    it.tag = tag; it.route = er; it.xaddr = ex; it.wr = ew; it.wt = ewt; it.go = ego;
    q.push_back(it);
    tgt = mon_done + 1;
    @(negedge clk);
    req = 1'b1; kind = k; addr = a;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      req = poke && (c == 2);
      if (poke && c == 2) begin kind = 3'd2; addr = 16'h1000; end
      host_t1 = (c == t1_at);
    end
    req = 1'b0; host_t1 = 1'b0;
    wait (mon_done >= tgt);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] s, input logic [18:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [18:0] ent(input int t, input int b, input int o, input int w, input int s);
    return {t[1:0], b[5:0], o[6:0], w[2:0], s[0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "valid", int'(valid), 0);
    chk("R12", "wait", int'(wait_s), 0);
    chk("R12", "wr_stb", int'(wr_stb), 0);
    chk("R12", "phys_go", int'(phys_go), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset map and route codes (R3)
    drive("R1", 3'd0, 16'h0123, 1, 'h0123, 0, 0, 0, 0, 0);
    drive("R1", 3'd1, 16'h0FFF, 1, 'h0FFF, 0, 0, 0, 0, 0);
    drive("R1", 3'd1, 16'h1000, 0, 'h1000, 0, 0, 0, 0, 0);
    drive("R1", 3'd1, 16'hCFFF, 0, 'hCFFF, 0, 0, 0, 0, 0);
    drive("R9", 3'd1, 16'hD000, 2, 'hD000, 0, 3, 2, 1, 0);
    drive("R9", 3'd1, 16'hFFFF, 2, 'hFFFF, 0, 5, 4, 3, 0);
    // R4 write strobe
    drive("R4", 3'd2, 16'h0FFF, 1, 'h0FFF, 0, 0, 0, 0, 0);
    drive("R4", 3'd2, 16'h5555, 0, 'h5555, 1, 0, 0, 0, 0);
    // R10 entry write, R2 translation
    cfg(8'd5, ent(0, 3, 'h40, 1, 0));
    drive("R2", 3'd1, 16'h0A7F, 0, 'h3807F, 0, 1, 0, 0, 0);
    drive("R10", 3'd2, 16'h0BFF, 0, 'h381FF, 1, 1, 0, 0, 0);
    // R3 function route
    cfg(8'd127, ent(3, 0, 0, 0, 0));
    drive("R3", 3'd1, 16'hFFFF, 3, 'h001FF, 0, 0, 0, 0, 0);
    drive("R3", 3'd2, 16'hFE00, 3, 'h00000, 0, 0, 0, 0, 0);
    // R5 unsynced pass-through
    cfg(8'd126, ent(2, 0, 126, 3, 0));
    drive("R5", 3'd2, 16'hFC10, 2, 'hFC10, 0, 3, 1, 0, 0);
    // R9 sync with zero region wait
    cfg(8'd120, ent(2, 0, 120, 0, 1));
    drive("R9", 3'd0, 16'hF000, 2, 'hF000, 0, 2, 3, 2, 0);
    // R6 fetch extra, R7 io extra
    cfg(8'h80, 19'({4'd5, 3'd3}));
    drive("R6", 3'd0, 16'h0A00, 0, 'h38000, 0, 4, 0, 0, 0);
    drive("R6", 3'd1, 16'h0A00, 0, 'h38000, 0, 1, 0, 0, 0);
    drive("R7", 3'd3, 16'h00D8, 2, 'h000D8, 0, 5, 1, 0, 0);
    drive("R7", 3'd4, 16'h1234, 2, 'h01234, 0, 5, 1, 0, 0);
    // R8 saturation
    cfg(8'h80, 19'({4'd12, 3'd7}));
    drive("R8", 3'd0, 16'h0123, 1, 'h0123, 0, 4, 0, 0, 0);
    drive("R8", 3'd3, 16'h0010, 2, 'h0010, 0, 8, 1, 0, 0);
    // R11 request during wait ignored
    drive("R11", 3'd0, 16'h0A00, 0, 'h38000, 0, 5, 0, 0, 1);
    drive("R11", 3'd1, 16'h1000, 0, 'h1000, 0, 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule